// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a processor subsystem drops into a reduced-clock state and when it comes back out. Software arms it by writing to a dedicated register on a simple register bus. The value written does not matter. The halt instruction must then be the very next instruction the CPU completes. The state the block then enters depends on two power-management bits. A sleep-enable bit chooses a light sleep. A stop-select bit, when sleep-enable is clear, chooses a deep stop.

While the CPU sits in a low-power state, the block watches a vector of interrupt requests. Each request is tagged as coming from an external pin or an on-chip peripheral, and each carries a priority. In sleep, any request qualifies as a wakeup. In stop, only external requests qualify. A qualifying request always returns the clocks to the run state. The CPU itself resumes only when the request's priority is strictly above the current CPU mask level. Otherwise the CPU stays halted with clocks running, and it resumes on the first later unmasked request. An ordinary halt, with no arm in effect, also leaves the clocks running and waits for an unmasked request.

Top module: `lpm_ctrl`

## Requirements
- R1: A write to the arm address (byte offset 0x0E) arms the block whatever the write data, zero or non-zero.
- R2: An armed halt that is the first instruction completed after the arm write moves `clk_state` to a low-power value on the following clock edge and sets `cpu_halted`.
- R3: Any other instruction completed between the arm write and the halt cancels the arm, so the later halt leaves `clk_state` at run (0) with `cpu_halted` set.
- R4: With sleep-enable set at the armed halt, `clk_state` becomes sleep (1), whatever stop-select holds.
- R5: With sleep-enable clear and stop-select set at the armed halt, `clk_state` becomes stop (2).
- R6: With both mode bits clear at the armed halt, `clk_state` stays run (0) and the CPU is halted as in an ordinary halt.
- R7: In sleep, any interrupt request, external (`irq_ext`=1) or on-chip (`irq_ext`=0), returns `clk_state` to run on the next edge.
- R8: In stop, on-chip requests leave `clk_state` at stop, and an external request returns it to run on the next edge.
- R9: A qualifying request whose priority is not above `cpu_mask` returns the clocks to run but keeps `cpu_halted` set and `cpu_resume` low.
- R10: While halted, a qualifying request with priority above `cpu_mask` raises `cpu_resume` for exactly one cycle on the next edge and clears `cpu_halted`. This holds from run, sleep or stop.
- R11: A read of the arm address returns zero and does not arm. A write to any other address does not arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register bus access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | DATA_W (16) | Write data (ignored by the arm register) |
| reg_rdata | output | DATA_W (16) | Read data, always zero |
| pm_sleep_en | input | 1 | Sleep-enable bit from the power management register |
| pm_stop_sel | input | 1 | Stop-select bit from the power management register |
| insn_valid | input | 1 | One instruction completed this cycle |
| insn_halt | input | 1 | The completed instruction is a halt |
| irq_req | input | N_IRQ (8) | Interrupt request per source |
| irq_ext | input | N_IRQ (8) | 1 = source is external, 0 = on-chip |
| irq_prio | input | N_IRQ*PRIO_W (24) | Priority per source, source i in bits [i*PRIO_W +: PRIO_W] |
| cpu_mask | input | PRIO_W (3) | Current CPU interrupt mask level |
| clk_state | output | 2 | 0 run, 1 sleep, 2 stop |
| cpu_halted | output | 1 | CPU is waiting in a halt |
| cpu_resume | output | 1 | One-cycle strobe that restarts the CPU |

## Verification
A stale arm flag shows up as a wrong `clk_state` one edge after the next halt: low power where run is due, or the reverse. A wrong wakeup qualifier shows on `clk_state` one edge after the request. Stop is the sharpest case, because a leaked on-chip request must leave the state untouched. A wrong mask comparison shows on `cpu_resume` and `cpu_halted` on that same edge. Because of this, the bench compares every output against a reference model on every cycle, so any divergence is caught within one cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    CS_RUN   = 2'd0,
    CS_SLEEP = 2'd1,
    CS_STOP  = 2'd2
  } clk_state_e;
endpackage

// File: rtl/lpm_arm.sv
module lpm_arm #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter logic [ADDR_W-1:0] ARM_ADDR = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              insn_valid,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              armed
);
  logic wr_hit;
  logic armed_d, armed_q;

  // Only a write to the arm offset counts; data is not looked at.
  assign wr_hit = reg_valid && reg_write && (reg_addr == ARM_ADDR);

  // Register is write-only: reads return zero.
  assign reg_rdata = '0;

  // A completed instruction consumes the arm; a write this cycle wins.
  always_comb begin
    armed_d = armed_q;
    if (wr_hit)          armed_d = 1'b1;
    else if (insn_valid) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

  // R1: a non-zero data write arms just as a zero write does
  a_r1_any_data_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (reg_wdata != '0)) |=> armed_q);

  // R3: an instruction with no new arm write leaves the block disarmed
  a_r3_insn_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !wr_hit) |=> !armed_q);

  // R11: reads and foreign writes never set the arm
  a_r11_no_spurious_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !(reg_valid && reg_write && reg_addr == ARM_ADDR)) |=> !armed_q);
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake
  import lpm_pkg::*;
#(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned PRIO_W = 3
) (
  input  clk_state_e              state,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_ext,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_mask,
  output logic                    wake_any,
  output logic                    resume_any
);
  logic [N_IRQ-1:0] qual;
  logic [N_IRQ-1:0] unmasked;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    // Stop admits only external sources; sleep and run admit all.
    assign qual[i]     = irq_req[i] && ((state != CS_STOP) || irq_ext[i]);
    assign unmasked[i] = irq_prio[i*PRIO_W +: PRIO_W] > cpu_mask;
  end

  assign wake_any   = |qual;
  assign resume_any = |(qual & unmasked);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_done,
  input  logic       armed,
  input  logic       sleep_en,
  input  logic       stop_sel,
  input  logic       wake_any,
  input  logic       resume_any,
  output clk_state_e state,
  output logic       halted,
  output logic       resume
);
  clk_state_e state_d, state_q;
  logic       halted_d, halted_q;
  logic       resume_d, resume_q;
  clk_state_e mode_sel;

  always_comb begin
    if (sleep_en)      mode_sel = CS_SLEEP;
    else if (stop_sel) mode_sel = CS_STOP;
    else               mode_sel = CS_RUN;
  end

  always_comb begin
    state_d  = state_q;
    halted_d = halted_q;
    resume_d = 1'b0;
    if (!halted_q) begin
      if (halt_done) begin
        halted_d = 1'b1;
        state_d  = armed ? mode_sel : CS_RUN;
      end
    end else begin
      if ((state_q != CS_RUN) && wake_any) state_d = CS_RUN;
      if (resume_any) begin
        halted_d = 1'b0;
        resume_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CS_RUN;
      halted_q <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      halted_q <= halted_d;
      resume_q <= resume_d;
    end
  end

  assign state  = state_q;
  assign halted = halted_q;
  assign resume = resume_q;

  // R2: low power is reached only through an armed halt
  a_r2_entry_needs_armed_halt: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != CS_RUN) && ($past(state_q) == CS_RUN)) |-> $past(halt_done && armed));

  // R9: the clocks are never gated while the CPU runs
  a_r9_lowpower_implies_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CS_RUN) |-> halted_q);

  // R10: resume strobe lasts one cycle
  a_r10_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |=> !resume_q);

  // R10: resume only ends a halt
  a_r10_resume_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> (!halted_q && $past(halted_q)));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] ARM_ADDR = 8'h0E
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_valid,
  input  logic                    reg_write,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    pm_sleep_en,
  input  logic                    pm_stop_sel,
  input  logic                    insn_valid,
  input  logic                    insn_halt,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_ext,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_mask,
  output logic [1:0]              clk_state,
  output logic                    cpu_halted,
  output logic                    cpu_resume
);
  logic       armed;
  logic       wake_any, resume_any;
  clk_state_e state;

  lpm_arm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARM_ADDR(ARM_ADDR)) u_arm (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .insn_valid(insn_valid),
    .reg_rdata(reg_rdata), .armed(armed)
  );

  lpm_wake #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_wake (
    .state(state), .irq_req(irq_req), .irq_ext(irq_ext),
    .irq_prio(irq_prio), .cpu_mask(cpu_mask),
    .wake_any(wake_any), .resume_any(resume_any)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .halt_done(insn_valid && insn_halt), .armed(armed),
    .sleep_en(pm_sleep_en), .stop_sel(pm_stop_sel),
    .wake_any(wake_any), .resume_any(resume_any),
    .state(state), .halted(cpu_halted), .resume(cpu_resume)
  );

  assign clk_state = state;

  // R8: on-chip requests cannot lift a stop
  a_r8_stop_ignores_onchip: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CS_STOP) && !(|(irq_req & irq_ext))) |=> (state == CS_STOP));

  // R7: in sleep any request wakes the clocks
  a_r7_sleep_any_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == CS_SLEEP) && (|irq_req)) |=> (state == CS_RUN));
endmodule

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
  localparam int N = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_valid, reg_write;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic pm_sleep_en, pm_stop_sel, insn_valid, insn_halt;
  logic [N-1:0] irq_req, irq_ext;
  logic [N*PW-1:0] irq_prio;
  logic [PW-1:0] cpu_mask;
  logic [1:0] clk_state;
  logic cpu_halted, cpu_resume;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  bit m_armed, m_halted, m_resume;
  int m_state;

  always #2.5 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pm_sleep_en(pm_sleep_en), .pm_stop_sel(pm_stop_sel),
    .insn_valid(insn_valid), .insn_halt(insn_halt),
    .irq_req(irq_req), .irq_ext(irq_ext), .irq_prio(irq_prio), .cpu_mask(cpu_mask),
    .clk_state(clk_state), .cpu_halted(cpu_halted), .cpu_resume(cpu_resume)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit qualifies(int i);
    return irq_req[i] && (m_state != 2 || irq_ext[i]);
  endfunction

  function automatic bit above_mask(int i);
    return irq_prio[i*PW +: PW] > cpu_mask;
  endfunction

  // Reference model, one clock edge, from the requirements
  task automatic model_edge();
    bit wr, wake, res;
    int nstate;
    bit nhalt;
    wr = reg_valid && reg_write && reg_addr == 8'h0E;
    wake = 0; res = 0;
    for (int i = 0; i < N; i++) begin
      if (qualifies(i)) begin
        wake = 1;
        if (above_mask(i)) res = 1;
      end
    end
    nstate = m_state; nhalt = m_halted; m_resume = 0;
    if (!m_halted) begin
      if (insn_valid && insn_halt) begin
        nhalt = 1;
        nstate = !m_armed ? 0 : pm_sleep_en ? 1 : pm_stop_sel ? 2 : 0;
      end
    end else begin
      if (m_state != 0 && wake) nstate = 0;
      if (res) begin nhalt = 0; m_resume = 1; end
    end
    m_state = nstate; m_halted = nhalt;
    if (wr) m_armed = 1; else if (insn_valid) m_armed = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("model clk_state", int'(clk_state), m_state);
    chk("model cpu_halted", int'(cpu_halted), int'(m_halted));
    chk("model cpu_resume", int'(cpu_resume), int'(m_resume));
  endtask

  task automatic idle();
    reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
    insn_valid = 0; insn_halt = 0; irq_req = 0;
  endtask

  task automatic bus(bit wr, logic [7:0] a, logic [15:0] d);
    idle(); reg_valid = 1; reg_write = wr; reg_addr = a; reg_wdata = d;
    step(); idle();
  endtask

  task automatic insn(bit halt);
    idle(); insn_valid = 1; insn_halt = halt; step(); idle();
  endtask

  task automatic irq(int src, bit ext, logic [PW-1:0] prio);
    idle(); irq_req[src] = 1; irq_ext[src] = ext; irq_prio[src*PW +: PW] = prio;
    step(); idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; idle(); irq_ext = 0; irq_prio = 0; cpu_mask = 3'd2;
    pm_sleep_en = 0; pm_stop_sel = 0;
    m_armed = 0; m_halted = 0; m_resume = 0; m_state = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset clk_state", int'(clk_state), 0);
    chk("reset cpu_halted", int'(cpu_halted), 0);
    chk("reset cpu_resume", int'(cpu_resume), 0);

    // R1 R2 R4: zero-data arm, both bits set -> sleep
    pm_sleep_en = 1; pm_stop_sel = 1;
    bus(1, 8'h0E, 16'h0000);
    insn(1);
    chk("R4 sleep chosen", int'(clk_state), 1);
    chk("R2 halted in low power", int'(cpu_halted), 1);
    // R7 R10: on-chip unmasked request in sleep
    irq(3, 0, 3'd5);
    chk("R7 sleep exit on-chip", int'(clk_state), 0);
    chk("R10 resume strobe", int'(cpu_resume), 1);
    chk("R10 halt cleared", int'(cpu_halted), 0);
    step();
    chk("R10 strobe one cycle", int'(cpu_resume), 0);

    // R5 R8 R9 R10: stop, on-chip ignored, masked external, then unmasked
    pm_sleep_en = 0; pm_stop_sel = 1; cpu_mask = 3'd3;
    bus(1, 8'h0E, 16'hA5A5);
    insn(1);
    chk("R5 stop chosen", int'(clk_state), 2);
    irq(1, 0, 3'd6);
    chk("R8 on-chip ignored in stop", int'(clk_state), 2);
    chk("R8 no resume from on-chip", int'(cpu_resume), 0);
    irq(4, 1, 3'd1);
    chk("R8 external exits stop", int'(clk_state), 0);
    chk("R9 masked keeps halt", int'(cpu_halted), 1);
    chk("R9 masked no resume", int'(cpu_resume), 0);
    irq(3, 1, 3'd3);
    chk("R9 equal priority masked", int'(cpu_resume), 0);
    irq(5, 0, 3'd7);
    chk("R10 later unmasked resumes", int'(cpu_resume), 1);

    // R3: intervening instruction cancels arm
    pm_sleep_en = 1;
    bus(1, 8'h0E, 16'h0001);
    insn(0);
    insn(1);
    chk("R3 cancelled arm stays run", int'(clk_state), 0);
    chk("R3 ordinary halt", int'(cpu_halted), 1);
    irq(0, 0, 3'd7);

    // R6: neither mode bit
    pm_sleep_en = 0; pm_stop_sel = 0;
    bus(1, 8'h0E, 16'hFFFF);
    insn(1);
    chk("R6 no mode stays run", int'(clk_state), 0);
    chk("R6 halted", int'(cpu_halted), 1);
    irq(0, 1, 3'd7);

    // R11: read and foreign write do not arm
    pm_sleep_en = 1;
    idle(); reg_valid = 1; reg_write = 0; reg_addr = 8'h0E;
    #1 chk("R11 read data zero", int'(reg_rdata), 0);
    step(); idle();
    insn(1);
    chk("R11 read did not arm", int'(clk_state), 0);
    irq(2, 1, 3'd7);
    bus(1, 8'h0C, 16'h1234);
    insn(1);
    chk("R11 other address did not arm", int'(clk_state), 0);
    irq(2, 1, 3'd7);

    // constrained random against the model
    for (int c = 0; c < 4000; c++) begin
      idle();
      pm_sleep_en = 1'($urandom % 2);
      pm_stop_sel = 1'($urandom % 2);
      cpu_mask = PW'($urandom);
      irq_ext = N'($urandom);
      irq_prio = (N*PW)'($urandom);
      if ($urandom % 5 == 0) irq_req = N'($urandom) & N'($urandom);
      case ($urandom % 12)
        0, 1: begin reg_valid = 1; reg_write = 1; reg_addr = 8'h0E; reg_wdata = 16'($urandom); end
        2:    begin reg_valid = 1; reg_write = 0; reg_addr = 8'h0E; end
        3:    begin reg_valid = 1; reg_write = 1; reg_addr = 8'($urandom); reg_wdata = 16'($urandom); end
        default: ;
      endcase
      if (!m_halted && ($urandom % 2 == 0)) begin
        insn_valid = 1; insn_halt = ($urandom % 3 == 0);
      end
      step();
    end

    done = 1'b1;
    finish_run();
  end
endmodule